// File: doc/BRIEF.md
# Exception and Interrupt Dispatch Unit

This unit sits at the boundary between two instructions and decides whether the program counter must be redirected. It holds the processor status word, the saved exception PC and status, the exception cause, the double-exception PC, the vector base, a free-running instruction counter and three compare registers. It takes the current PC together with an optional synchronous exception request and its cause code. It also takes a vector of pending interrupt lines, an enable mask and a 3-bit priority level for each line. On each retired instruction (`step_i`) it produces a redirect flag and a target address in the same cycle. Its saved state updates at the clock edge that closes that step.

A synchronous exception always beats an interrupt. Among the interrupts that can be taken, the one with the highest level wins. An exception raised while exception mode is already set takes a separate double-exception path, and the first-level saved registers are left as they were. A small write port loads the status word, the vector base and the compare registers. The compare registers act as three timer interrupt sources on fixed lines. In the first cycle after reset the unit steers to a fixed boot address that does not depend on the vector base.

Top module: `trap_steer`

## Requirements
- R1: After reset the status word and the counter are 0 and the vector base is `VB_RST`. In the first cycle after reset is released, `redirect_o` is 1 and `target_o` is 0x4000_0400, with no step needed. A step in that cycle is not acted on.
- R2: A step with `exc_req_i`=1 while exception mode (status bit 4) is clear stores `pc_i` in the saved PC, the old status word in the saved status and `exc_cause_i` in the cause register. It sets status bit 4 and raises the interrupt level (status bits 3:0) to at least 1.
- R3: A step with `exc_req_i`=1 while status bit 4 is set redirects to vector base + 0x1C0 and stores `pc_i` in the double-exception PC. The saved PC, saved status and cause are left unchanged.
- R4: A first-level exception or a level-1 interrupt targets vector base + 0x180 when user mode (status bit 5) is 0, and vector base + 0x200 when it is 1.
- R5: A line is eligible only when it is pending and enabled and its level is greater than status bits 3:0. A level-1 line also needs status bit 4 clear. Levels 0 and 6 are never taken. Disabled pending lines have no effect.
- R6: The eligible line with the highest level is taken. A level-1 interrupt behaves like R2 with cause 4. A level L from 2 to 5 targets vector base + 0x240 + 0x40*(L-2), level 7 targets vector base + 0x340, and both set status bits 3:0 to L and leave the saved registers unchanged.
- R7: When an exception request and an eligible interrupt arrive in the same step, the exception is taken.
- R8: The counter (`count_o`) increments once per step. When the incremented value equals compare register i, pending line `TMR_LINE0`+i is set at that clock edge and can be taken from the next step on.
- R9: Write port: `wr_sel_i`=0 writes the status word (only bits 18:16 and 11:0 are kept), 1 writes the vector base, and 2, 3, 4 write compare registers 0, 1, 2. Writing a compare register clears its pending line.
- R10: When a step redirects, a status-word write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One instruction retires this cycle |
| pc_i | input | 32 | PC of the instruction boundary |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 6 | Exception cause code |
| irq_pend_i | input | NLINE | Pending interrupt lines |
| irq_en_i | input | NLINE | Interrupt enable mask |
| irq_lvl_i | input | 3*NLINE | Level of each line, 3 bits per line |
| wr_en_i | input | 1 | State write strobe |
| wr_sel_i | input | 3 | State write select (R9) |
| wr_data_i | input | 32 | State write data |
| redirect_o | output | 1 | Redirect the PC this cycle |
| target_o | output | 32 | Redirect target |
| ps_o | output | 32 | Status word |
| epc_o | output | 32 | Saved exception PC |
| eps_o | output | 32 | Saved status word |
| cause_o | output | 6 | Exception cause |
| depc_o | output | 32 | Double-exception PC |
| count_o | output | 32 | Instruction counter |

## Verification
`redirect_o` and `target_o` are combinational. They are due in the same cycle as the step that causes them, so the monitor compares them at the falling edge of that cycle against the item the driver queued for the step. Saved PC, status, cause, double PC and counter change at the rising edge that closes the step, and the bench reads them just after that edge. A compare match only affects the step after the match, so the timer sequence expects two quiet steps before the redirect.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [31:0] RESET_PC   = 32'h4000_0400;
  localparam logic [31:0] OFS_KERNEL = 32'h180;
  localparam logic [31:0] OFS_DOUBLE = 32'h1C0;
  localparam logic [31:0] OFS_USER   = 32'h200;
  localparam logic [31:0] OFS_LVL2   = 32'h240;
  localparam logic [31:0] OFS_NMI    = 32'h340;
  localparam logic [31:0] PS_MASK    = 32'h0007_0FFF;
  localparam int          PS_EXCM    = 4;
  localparam int          PS_UM      = 5;
  localparam logic [5:0]  CAUSE_IRQ1 = 6'd4;
  typedef enum logic [2:0] {
    SEL_PS = 3'd0, SEL_VB = 3'd1, SEL_CMP0 = 3'd2
  } wr_sel_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NLINE = 16
) (
  input  logic [NLINE-1:0]   pend_i,
  input  logic [NLINE-1:0]   en_i,
  input  logic [3*NLINE-1:0] lvl_i,
  input  logic [3:0]         il_i,
  input  logic               excm_i,
  output logic               hit_o,
  output logic [2:0]         win_lvl_o
);
  always_comb begin
    logic [2:0] l;
    win_lvl_o = 3'd0;
    for (int i = 0; i < NLINE; i++) begin
      l = lvl_i[3*i +: 3];
      if (pend_i[i] && en_i[i] && l != 3'd0 && l != 3'd6 &&
          ({1'b0, l} > il_i) && !(l == 3'd1 && excm_i) && l > win_lvl_o)
        win_lvl_o = l;
    end
    hit_o = (win_lvl_o != 3'd0);
    if (hit_o) begin
      a_r5_above_mask: assert ({1'b0, win_lvl_o} > il_i);
    end
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int NCMP = 3,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [NCMP-1:0] cmp_we_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    count_o,
  output logic [NCMP-1:0] tpend_o
);
  logic [W-1:0] cnt_q, cnt_d;
  assign cnt_d   = cnt_q + 1'b1;
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [W-1:0] cmp_q;
    logic         pend_q, pend_d;
    always_comb begin
      pend_d = pend_q;
      if (cmp_we_i[i])                      pend_d = 1'b0;
      else if (step_i && cnt_d == cmp_q)    pend_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (cmp_we_i[i]) cmp_q <= wdata_i;
        pend_q <= pend_d;
      end
    end
    assign tpend_o[i] = pend_q;

    a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !cmp_we_i[i] && (cnt_q + 1'b1) == cmp_q) |=> tpend_o[i]);
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we_i[i] |=> !tpend_o[i]);
  end
endmodule

// File: rtl/trap_steer.sv
module trap_steer
  import trap_pkg::*;
#(
  parameter int          NLINE     = 16,
  parameter int          NCMP      = 3,
  parameter int          TMR_LINE0 = 6,
  parameter logic [31:0] VB_RST    = 32'h4000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [31:0]        pc_i,
  input  logic               exc_req_i,
  input  logic [5:0]         exc_cause_i,
  input  logic [NLINE-1:0]   irq_pend_i,
  input  logic [NLINE-1:0]   irq_en_i,
  input  logic [3*NLINE-1:0] irq_lvl_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [31:0]        wr_data_i,
  output logic               redirect_o,
  output logic [31:0]        target_o,
  output logic [31:0]        ps_o,
  output logic [31:0]        epc_o,
  output logic [31:0]        eps_o,
  output logic [5:0]         cause_o,
  output logic [31:0]        depc_o,
  output logic [31:0]        count_o
);
  logic              boot_q;
  logic [31:0]       ps_q, ps_d, epc_q, epc_d, eps_q, eps_d, depc_q, depc_d, vb_q, vb_d;
  logic [5:0]        cause_q, cause_d;
  logic              live_step;
  logic [NCMP-1:0]   cmp_we, tpend;
  logic [NLINE-1:0]  tmr_vec, pend_all;
  logic              irq_hit;
  logic [2:0]        win_lvl;

  assign live_step = step_i && !boot_q;

  for (genvar i = 0; i < NCMP; i++) begin : g_we
    assign cmp_we[i] = wr_en_i && !boot_q && (wr_sel_i == SEL_CMP0 + 3'(i));
  end

  always_comb begin
    tmr_vec = '0;
    for (int i = 0; i < NCMP; i++) tmr_vec[TMR_LINE0 + i] = tpend[i];
  end
  assign pend_all = irq_pend_i | tmr_vec;

  cycle_timer #(.NCMP(NCMP), .W(32)) u_tmr (
    .clk(clk), .rst_n(rst_n), .step_i(live_step), .cmp_we_i(cmp_we),
    .wdata_i(wr_data_i), .count_o(count_o), .tpend_o(tpend)
  );

  irq_pick #(.NLINE(NLINE)) u_pick (
    .pend_i(pend_all), .en_i(irq_en_i), .lvl_i(irq_lvl_i), .il_i(ps_q[3:0]),
    .excm_i(ps_q[PS_EXCM]), .hit_o(irq_hit), .win_lvl_o(win_lvl)
  );

  always_comb begin
    ps_d = ps_q;  epc_d = epc_q;  eps_d = eps_q;
    cause_d = cause_q;  depc_d = depc_q;  vb_d = vb_q;
    redirect_o = 1'b0;
    target_o   = RESET_PC;
    if (boot_q) begin
      redirect_o = 1'b1;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_PS) ps_d = wr_data_i & PS_MASK;
      if (wr_en_i && wr_sel_i == SEL_VB) vb_d = wr_data_i;
      if (step_i && (exc_req_i || irq_hit)) begin
        redirect_o = 1'b1;
        ps_d = ps_q;
        if (exc_req_i && ps_q[PS_EXCM]) begin
          depc_d   = pc_i;
          target_o = vb_q + OFS_DOUBLE;
        end else if (exc_req_i || win_lvl == 3'd1) begin
          epc_d   = pc_i;
          eps_d   = ps_q;
          cause_d = exc_req_i ? exc_cause_i : CAUSE_IRQ1;
          ps_d[PS_EXCM] = 1'b1;
          if (ps_q[3:0] == 4'd0) ps_d[3:0] = 4'd1;
          target_o = vb_q + (ps_q[PS_UM] ? OFS_USER : OFS_KERNEL);
        end else begin
          ps_d[3:0] = {1'b0, win_lvl};
          target_o  = (win_lvl == 3'd7) ? vb_q + OFS_NMI
                    : vb_q + OFS_LVL2 + (({29'd0, win_lvl} - 32'd2) << 6);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      ps_q    <= '0;
      epc_q   <= '0;
      eps_q   <= '0;
      cause_q <= '0;
      depc_q  <= '0;
      vb_q    <= VB_RST;
    end else begin
      boot_q <= 1'b0;
      if (!boot_q) begin
        ps_q    <= ps_d;
        epc_q   <= epc_d;
        eps_q   <= eps_d;
        cause_q <= cause_d;
        depc_q  <= depc_d;
        vb_q    <= vb_d;
      end
    end
  end

  assign ps_o    = ps_q;
  assign epc_o   = epc_q;
  assign eps_o   = eps_q;
  assign cause_o = cause_q;
  assign depc_o  = depc_q;

  a_r1_boot_once: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> !boot_q);
  a_r2_first_save: assert property (@(posedge clk) disable iff (!rst_n)
    (live_step && exc_req_i && !ps_q[PS_EXCM]) |=>
      (epc_q == $past(pc_i) && ps_q[PS_EXCM] && ps_q[3:0] != 4'd0));
  a_r3_double_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (live_step && exc_req_i && ps_q[PS_EXCM]) |=>
      (depc_q == $past(pc_i) && $stable(epc_q) && $stable(cause_q)));
  a_r7_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (live_step && exc_req_i && !ps_q[PS_EXCM]) |=> cause_q == $past(exc_cause_i));
  a_r10_quiet_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !boot_q) |-> !redirect_o);
endmodule

// File: tb/trap_steer_test.sv
module trap_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NLINE = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               step_i, exc_req_i, wr_en_i;
  logic [31:0]        pc_i, wr_data_i;
  logic [5:0]         exc_cause_i;
  logic [NLINE-1:0]   irq_pend_i, irq_en_i;
  logic [3*NLINE-1:0] irq_lvl_i;
  logic [2:0]         wr_sel_i;
  logic               redirect_o;
  logic [31:0]        target_o, ps_o, epc_o, eps_o, depc_o, count_o;
  logic [5:0]         cause_o;

  int nchk = 0, nfail = 0;
  int exp_cnt = 0;
  logic [32:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_steer uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .pc_i(pc_i),
    .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
    .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i), .irq_lvl_i(irq_lvl_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .redirect_o(redirect_o), .target_o(target_o), .ps_o(ps_o),
    .epc_o(epc_o), .eps_o(eps_o), .cause_o(cause_o), .depc_o(depc_o),
    .count_o(count_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare the redirect decision of every step at the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && step_i === 1'b1) begin
      if (expq.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL scoreboard: step with no expected item");
      end else begin
        logic [32:0] e;
        string       t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({t, " redirect"}, {31'd0, redirect_o}, {31'd0, e[32]});
        if (e[32]) chk({t, " target"}, target_o, e[31:0]);
      end
    end
  end

  task automatic do_step(string tag, logic [31:0] pc, logic exc, logic [5:0] cause,
                         logic red, logic [31:0] tgt);
    @(posedge clk); #1;
    step_i = 1'b1; pc_i = pc; exc_req_i = exc; exc_cause_i = cause;
    expq.push_back({red, tgt});
    tagq.push_back(tag);
    exp_cnt++;
    @(posedge clk); #1;
    step_i = 1'b0; exc_req_i = 1'b0;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] data);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic set_line(int line, logic [2:0] lvl, logic en, logic pend);
    irq_lvl_i[3*line +: 3] = lvl;
    irq_en_i[line]   = en;
    irq_pend_i[line] = pend;
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  localparam logic [31:0] VB = 32'h4008_0000;

  initial begin
    rst_n = 1'b0; step_i = 0; exc_req_i = 0; wr_en_i = 0;
    pc_i = '0; exc_cause_i = '0; wr_sel_i = '0; wr_data_i = '0;
    irq_pend_i = '0; irq_en_i = '0; irq_lvl_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 boot redirect", {31'd0, redirect_o}, 32'd1);
    chk("R1 boot target", target_o, 32'h4000_0400);
    chk("R1 reset status", ps_o, 32'd0);
    chk("R1 reset count", count_o, 32'd0);
    @(posedge clk); #1;
    chk("R1 boot is one cycle", {31'd0, redirect_o}, 32'd0);

    wr(3'd1, VB);
    do_step("R8 plain step", 32'h400D_0000, 0, 0, 0, 0);
    chk("R8 count after one step", count_o, 32'd1);

    do_step("R2 R4 kernel exception", 32'h400D_0010, 1, 6'd6, 1, VB + 32'h180);
    chk("R2 saved pc", epc_o, 32'h400D_0010);
    chk("R2 saved status", eps_o, 32'd0);
    chk("R2 cause", {26'd0, cause_o}, 32'd6);
    chk("R2 status after", ps_o, 32'h11);

    do_step("R3 double exception", 32'h400D_0020, 1, 6'd9, 1, VB + 32'h1C0);
    chk("R3 double pc", depc_o, 32'h400D_0020);
    chk("R3 saved pc kept", epc_o, 32'h400D_0010);
    chk("R3 cause kept", {26'd0, cause_o}, 32'd6);

    wr(3'd0, 32'hFFFF_F020);
    chk("R9 status write mask", ps_o, 32'h0007_F020 & 32'h0007_0FFF);
    wr(3'd0, 32'h20);
    set_line(3, 3'd1, 1, 1);
    do_step("R4 R6 user level-1 irq", 32'h400D_0030, 0, 0, 1, VB + 32'h200);
    chk("R6 level-1 cause", {26'd0, cause_o}, 32'd4);
    chk("R6 level-1 saved status", eps_o, 32'h20);
    chk("R6 level-1 status", ps_o, 32'h31);
    chk("R6 level-1 saved pc", epc_o, 32'h400D_0030);

    wr(3'd0, 32'h10);
    do_step("R5 level-1 gated by exception mode", 32'h400D_0038, 0, 0, 0, 0);
    set_line(4, 3'd3, 1, 1);
    do_step("R6 level-3 irq", 32'h400D_0040, 0, 0, 1, VB + 32'h280);
    chk("R6 level-3 status", ps_o, 32'h13);
    chk("R6 saved pc untouched", epc_o, 32'h400D_0030);

    set_line(3, 3'd1, 0, 0); set_line(4, 3'd3, 0, 0);
    wr(3'd0, 32'h04);
    set_line(9, 3'd4, 1, 1);
    do_step("R5 level equal to mask", 32'h400D_0050, 0, 0, 0, 0);
    set_line(10, 3'd5, 1, 1);
    do_step("R6 level-5 irq", 32'h400D_0058, 0, 0, 1, VB + 32'h300);
    chk("R6 level-5 status", ps_o, 32'h05);

    wr(3'd0, 32'h0);
    set_line(10, 3'd5, 0, 1);
    set_line(2, 3'd2, 1, 1);
    do_step("R5 R6 disabled ignored, highest wins", 32'h400D_0060, 0, 0, 1, VB + 32'h2C0);
    chk("R6 level-4 status", ps_o, 32'h04);

    set_line(2, 3'd2, 0, 0); set_line(9, 3'd4, 0, 0); set_line(10, 3'd5, 0, 0);
    wr(3'd0, 32'h06);
    set_line(11, 3'd7, 1, 1);
    set_line(12, 3'd6, 1, 1);
    do_step("R6 level-7 irq", 32'h400D_0070, 0, 0, 1, VB + 32'h340);
    chk("R6 level-7 status", ps_o, 32'h07);
    set_line(11, 3'd7, 0, 0);
    wr(3'd0, 32'h0);
    do_step("R5 level 6 never taken", 32'h400D_0078, 0, 0, 0, 0);
    set_line(12, 3'd6, 0, 0);

    set_line(9, 3'd4, 1, 1);
    do_step("R7 exception beats irq", 32'h400D_0080, 1, 6'd3, 1, VB + 32'h180);
    chk("R7 cause", {26'd0, cause_o}, 32'd3);
    chk("R7 status", ps_o, 32'h11);
    set_line(9, 3'd4, 0, 0);

    // R10: status write together with a redirecting step is dropped
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 32'h0;
    step_i = 1'b1; pc_i = 32'h400D_0088; exc_req_i = 1'b1; exc_cause_i = 6'd5;
    expq.push_back({1'b1, VB + 32'h1C0}); tagq.push_back("R10 double with write");
    exp_cnt++;
    @(posedge clk); #1;
    step_i = 1'b0; exc_req_i = 1'b0; wr_en_i = 1'b0;
    chk("R10 status write dropped", ps_o, 32'h11);

    wr(3'd0, 32'h0);
    set_line(6, 3'd2, 1, 0);
    wr(3'd2, exp_cnt + 2);
    do_step("R8 before match", 32'h400D_0090, 0, 0, 0, 0);
    do_step("R8 match step", 32'h400D_0094, 0, 0, 0, 0);
    do_step("R8 timer irq", 32'h400D_0098, 0, 0, 1, VB + 32'h240);
    chk("R8 timer level status", ps_o, 32'h02);
    wr(3'd0, 32'h0);
    do_step("R8 timer still pending", 32'h400D_00A0, 0, 0, 1, VB + 32'h240);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    do_step("R9 compare write clears", 32'h400D_00A8, 0, 0, 0, 0);
    chk("R8 count tracks steps", count_o, exp_cnt);

    repeat (2) @(posedge clk);
    if (expq.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL scoreboard: %0d items left", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule